// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital sequencer of a LIN bus transceiver with a built-in supply regulator. It decides which of five operating modes the transceiver is in: unpowered, pre-normal, normal, silent or sleep. From that mode it drives the enables for the regulator, the bus termination, the watchdog and the bus driver, and the levels seen on the receive pin and on the transmit pin. The transmit pin turns into an output while a wake-up is being reported. Its inputs are the enable pin, the transmit-data pin, a supply-present flag, a regulator-undervoltage flag, an already-filtered bus-dominant level and the level on a local wake pin.

The host picks a low-power mode with a single gesture. It pulls enable low, and the level it holds on the transmit pin during a short select window decides between silent and sleep. In either low-power mode, two independent debounce filters watch the bus and the wake pin. When one of them fires, the device returns to pre-normal and reports the wake. The receive pin goes low to interrupt the host, and the transmit pin shows which source fired. A dominant time-out keeps a stuck-low transmit input from holding the bus dominant for good. All time constants are parameters counted in system-clock cycles.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the mode is unpowered (mode code 0) and reg_on_o, term_en_o, wd_en_o, bus_drv_o, rxd_o and txd_oe_o are all 0. The block stays unpowered while vs_ok_i is 0 and moves to pre-normal (code 1) on the first clock edge that sees vs_ok_i high.
- R2: A clock edge that sees vs_ok_i low puts any mode into unpowered.
- R3: In pre-normal, reg_on_o, term_en_o and wd_en_o are 1 and bus_drv_o is 0. The mode holds until an edge sees en_i high, which enters normal (code 2). In normal, rxd_o equals the inverse of bus_dom_i and bus_drv_o equals the inverse of txd_i while the time-out has not fired.
- R4: A falling edge of en_i in normal opens a window of SEL_WIN_CYC cycles. If en_i stays low and txd_i keeps its level through the window, the block enters silent (code 3) when txd_i was high and sleep (code 4) when it was low. A change of txd_i or a return of en_i high inside the window leaves the block in normal.
- R5: Silent keeps reg_on_o at 1 with term_en_o, wd_en_o and bus_drv_o at 0 and rxd_o at 1. en_i high moves silent straight to normal. vcc_uv_i high moves silent or normal to pre-normal.
- R6: Sleep drives reg_on_o, rxd_o, term_en_o and wd_en_o to 0. en_i and vcc_uv_i have no effect on the mode in sleep.
- R7: In silent or sleep, bus_dom_i high for BUS_WAKE_CYC consecutive cycles is a remote wake and enters pre-normal. A shorter dominant pulse does nothing.
- R8: In silent or sleep, wake_n_i low for LOC_WAKE_CYC consecutive cycles is a local wake and enters pre-normal. A shorter low pulse does nothing.
- R9: After a wake, pre-normal holds rxd_o at 0 and txd_oe_o at 1, with txd_o at 1 for a remote wake and 0 for a local one, and term_en_o back at 1. Both flags clear on the edge that sees en_i high: txd_oe_o returns to 0 and rxd_o follows the bus again.
- R10: In normal, once txd_i has been low for DOM_TO_CYC consecutive cycles, bus_drv_o is forced to 0 even though txd_i stays low.
- R11: After a time-out the driver re-arms only after txd_i has been high for REARM_CYC consecutive cycles. A shorter high pulse leaves bus_drv_o at 0.
- R12: A wake source only counts after it has been seen inactive in a low-power mode, so a level that is already active on entry does not wake the device. Wake inputs have no effect in normal or pre-normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable pin level from the host |
| txd_i | input | 1 | Transmit-data pin level (low = dominant) |
| vs_ok_i | input | 1 | Battery supply above its threshold |
| vcc_uv_i | input | 1 | Regulator output undervoltage |
| bus_dom_i | input | 1 | Filtered bus level, 1 = dominant |
| wake_n_i | input | 1 | Local wake pin level, active low |
| mode_o | output | 3 | Current mode code |
| reg_on_o | output | 1 | Regulator enable |
| term_en_o | output | 1 | Bus termination enable |
| wd_en_o | output | 1 | Watchdog enable |
| bus_drv_o | output | 1 | Pull the bus dominant |
| rxd_o | output | 1 | Level on the receive pin |
| txd_oe_o | output | 1 | Transmit pin driven as an output |
| txd_o | output | 1 | Level driven on the transmit pin (1 = remote wake, 0 = local wake) |

## Verification
Directed sequences take every mode transition. For each one they probe one cycle before the expected change and one cycle after it. This separates a correct window or filter length from one that is off by a cycle. For the select window, an aborted attempt is compared with a held one, and a high transmit level with a low one, which separates silent entry from sleep entry. For wake-up, a short pulse on each wake source is compared with a long one, and a source that is already active on entry is compared with a fresh falling edge. The reported source level tells the remote path from the local one. A run of random transmit, bus and wake-pin values in normal mode checks that the driver and receive pin follow their inputs and that stray wake activity is ignored.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [2:0] {
    MD_UNPWR   = 3'd0,
    MD_PRENORM = 3'd1,
    MD_NORMAL  = 3'd2,
    MD_SILENT  = 3'd3,
    MD_SLEEP   = 3'd4
  } lin_mode_e;
endpackage

// File: rtl/lin_wake_filter.sv
// Debounce for one wake source: fires after HOLD_CYC consecutive active
// cycles, counted only once the source has been seen inactive (R7, R8, R12).
module lin_wake_filter #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic active_i,
  output logic hit_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;

  assign hit_o = enable_i && armed_q && active_i && (cnt_q == CW'(HOLD_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!enable_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!active_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && !hit_o) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lin_sel_window.sv
// Detects the enable falling edge in normal mode and qualifies the
// transmit level over the select window (R4).
module lin_sel_window #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic en_i,
  input  logic txd_i,
  output logic go_silent_o,
  output logic go_sleep_o
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic          en_q;
  logic          busy_q;
  logic          cap_q;
  logic [CW-1:0] cnt_q;
  logic          start;
  logic          keep;
  logic          done;

  assign start = arm_i && en_q && !en_i && !busy_q;
  assign keep  = arm_i && busy_q && !en_i && (txd_i == cap_q);
  assign done  = keep && (cnt_q == CW'(WIN_CYC - 1));

  assign go_silent_o = done && cap_q;
  assign go_sleep_o  = done && !cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      cap_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q <= en_i;
      if (start) begin
        busy_q <= 1'b1;
        cap_q  <= txd_i;
        cnt_q  <= '0;
      end else if (keep && !done) begin
        cnt_q  <= cnt_q + 1'b1;
      end else if (busy_q) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/lin_dom_timer.sv
// Dominant time-out with re-arm qualification (R10, R11).
module lin_dom_timer #(
  parameter int DOM_CYC   = 64,
  parameter int REARM_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic txd_i,
  output logic lock_o
);
  localparam int MAXC = (DOM_CYC > REARM_CYC) ? DOM_CYC : REARM_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          lock_q;
  logic [CW-1:0] cnt_q;

  assign lock_o = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!active_i) begin
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else if (lock_q) begin
      if (!txd_i) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(REARM_CYC - 1)) begin
        lock_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (txd_i) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(DOM_CYC - 1)) begin
        lock_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int SEL_WIN_CYC  = 64,
  parameter int BUS_WAKE_CYC = 1800,
  parameter int LOC_WAKE_CYC = 2600,
  parameter int DOM_TO_CYC   = 120000,
  parameter int REARM_CYC    = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       vs_ok_i,
  input  logic       vcc_uv_i,
  input  logic       bus_dom_i,
  input  logic       wake_n_i,
  output logic [2:0] mode_o,
  output logic       reg_on_o,
  output logic       term_en_o,
  output logic       wd_en_o,
  output logic       bus_drv_o,
  output logic       rxd_o,
  output logic       txd_oe_o,
  output logic       txd_o
);
  lin_mode_e mode_q, mode_d;
  logic      wk_pend_q, wk_pend_d;
  logic      wk_rem_q, wk_rem_d;
  logic      low_pwr;
  logic      bus_hit, loc_hit, wake_hit;
  logic      go_silent, go_sleep;
  logic      dom_lock;

  assign low_pwr  = (mode_q == MD_SILENT) || (mode_q == MD_SLEEP);
  assign wake_hit = bus_hit || loc_hit;

  lin_wake_filter #(.HOLD_CYC(BUS_WAKE_CYC)) i_bus_wake (
    .clk(clk), .rst_n(rst_n), .enable_i(low_pwr),
    .active_i(bus_dom_i), .hit_o(bus_hit));

  lin_wake_filter #(.HOLD_CYC(LOC_WAKE_CYC)) i_loc_wake (
    .clk(clk), .rst_n(rst_n), .enable_i(low_pwr),
    .active_i(!wake_n_i), .hit_o(loc_hit));

  lin_sel_window #(.WIN_CYC(SEL_WIN_CYC)) i_sel (
    .clk(clk), .rst_n(rst_n), .arm_i(mode_q == MD_NORMAL),
    .en_i(en_i), .txd_i(txd_i),
    .go_silent_o(go_silent), .go_sleep_o(go_sleep));

  lin_dom_timer #(.DOM_CYC(DOM_TO_CYC), .REARM_CYC(REARM_CYC)) i_dom (
    .clk(clk), .rst_n(rst_n), .active_i(mode_q == MD_NORMAL),
    .txd_i(txd_i), .lock_o(dom_lock));

  // next-state
  always_comb begin
    mode_d = mode_q;
    if (!vs_ok_i) begin
      mode_d = MD_UNPWR;
    end else begin
      unique case (mode_q)
        MD_UNPWR:   mode_d = MD_PRENORM;
        MD_PRENORM: if (en_i) mode_d = MD_NORMAL;
        MD_NORMAL: begin
          if (vcc_uv_i)       mode_d = MD_PRENORM;
          else if (go_silent) mode_d = MD_SILENT;
          else if (go_sleep)  mode_d = MD_SLEEP;
        end
        MD_SILENT: begin
          if (vcc_uv_i)      mode_d = MD_PRENORM;
          else if (en_i)     mode_d = MD_NORMAL;
          else if (wake_hit) mode_d = MD_PRENORM;
        end
        MD_SLEEP:   if (wake_hit) mode_d = MD_PRENORM;
        default:    mode_d = MD_UNPWR;
      endcase
    end
  end

  // wake flags
  always_comb begin
    wk_pend_d = wk_pend_q;
    wk_rem_d  = wk_rem_q;
    if (!vs_ok_i || en_i) begin
      wk_pend_d = 1'b0;
      wk_rem_d  = 1'b0;
    end else if (low_pwr && wake_hit) begin
      wk_pend_d = 1'b1;
      wk_rem_d  = bus_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_UNPWR;
      wk_pend_q <= 1'b0;
      wk_rem_q  <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      wk_pend_q <= wk_pend_d;
      wk_rem_q  <= wk_rem_d;
    end
  end

  // outputs
  always_comb begin
    reg_on_o  = 1'b0;
    term_en_o = 1'b0;
    wd_en_o   = 1'b0;
    bus_drv_o = 1'b0;
    rxd_o     = 1'b0;
    txd_oe_o  = 1'b0;
    txd_o     = 1'b1;
    unique case (mode_q)
      MD_PRENORM: begin
        reg_on_o  = 1'b1;
        term_en_o = 1'b1;
        wd_en_o   = 1'b1;
        rxd_o     = !wk_pend_q;
        txd_oe_o  = wk_pend_q;
        txd_o     = wk_rem_q;
      end
      MD_NORMAL: begin
        reg_on_o  = 1'b1;
        term_en_o = 1'b1;
        wd_en_o   = 1'b1;
        bus_drv_o = !txd_i && !dom_lock;
        rxd_o     = !bus_dom_i;
      end
      MD_SILENT: begin
        reg_on_o  = 1'b1;
        rxd_o     = 1'b1;
      end
      default: ;
    endcase
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk
  import lin_mode_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       txd_i,
  input logic       vs_ok_i,
  input logic       vcc_uv_i,
  input logic [2:0] mode_o,
  input logic       reg_on_o,
  input logic       term_en_o,
  input logic       wd_en_o,
  input logic       bus_drv_o,
  input logic       rxd_o,
  input logic       txd_oe_o
);
  p_unpwr_on_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_ok_i |=> mode_o == MD_UNPWR);

  p_prenorm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_ok_i && !en_i && mode_o == MD_PRENORM) |=> mode_o == MD_PRENORM);

  p_normal_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_ok_i && en_i && !vcc_uv_i && mode_o == MD_NORMAL) |=> mode_o == MD_NORMAL);

  p_silent_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_ok_i && en_i && !vcc_uv_i && mode_o == MD_SILENT) |=> mode_o == MD_NORMAL);

  p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_SLEEP) |-> (!reg_on_o && !rxd_o && !wd_en_o && !term_en_o));

  p_wake_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
    txd_oe_o |-> (mode_o == MD_PRENORM && !rxd_o));

  p_drive_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drv_o |-> (mode_o == MD_NORMAL && !txd_i));
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk i_lin_mode_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .txd_i(txd_i), .vs_ok_i(vs_ok_i),
  .vcc_uv_i(vcc_uv_i), .mode_o(mode_o), .reg_on_o(reg_on_o),
  .term_en_o(term_en_o), .wd_en_o(wd_en_o), .bus_drv_o(bus_drv_o),
  .rxd_o(rxd_o), .txd_oe_o(txd_oe_o));

// File: tb/test_lin_mode_ctrl.sv
`timescale 1ns/1ps
module test_lin_mode_ctrl;
  localparam int SEL   = 4;
  localparam int BUSW  = 8;
  localparam int LOCW  = 12;
  localparam int DOM   = 40;
  localparam int REARM = 4;

  localparam logic [2:0] M_UNP = 3'd0, M_PRE = 3'd1, M_NOR = 3'd2,
                         M_SIL = 3'd3, M_SLP = 3'd4;

  logic clk, rst_n, en, txd, vs_ok, vcc_uv, bus_dom, wake_n;
  logic [2:0] mode;
  logic reg_on, term_en, wd_en, bus_drv, rxd, txd_oe, txd_out;

  int n_chk = 0;
  int n_fail = 0;

  lin_mode_ctrl #(
    .SEL_WIN_CYC(SEL), .BUS_WAKE_CYC(BUSW), .LOC_WAKE_CYC(LOCW),
    .DOM_TO_CYC(DOM), .REARM_CYC(REARM)
  ) i_lin_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .txd_i(txd), .vs_ok_i(vs_ok),
    .vcc_uv_i(vcc_uv), .bus_dom_i(bus_dom), .wake_n_i(wake_n),
    .mode_o(mode), .reg_on_o(reg_on), .term_en_o(term_en), .wd_en_o(wd_en),
    .bus_drv_o(bus_drv), .rxd_o(rxd), .txd_oe_o(txd_oe), .txd_o(txd_out));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic exp_drive(logic t, int low_run);
    return !t && (low_run < DOM);
  endfunction

  function automatic logic exp_rxd_normal(logic b);
    return !b;
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic enter_low(logic t);
    txd = t; en = 1'b0;
    step(SEL + 1);
    txd = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int low_run;
    int seed_set;
    seed_set = $urandom(32'h51C0);
    rst_n = 1'b0; en = 1'b0; txd = 1'b1; vs_ok = 1'b0; vcc_uv = 1'b0;
    bus_dom = 1'b0; wake_n = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 mode", mode, M_UNP);
    chk("R1 outs", {reg_on, term_en, wd_en, bus_drv, rxd, txd_oe}, 6'b0);
    rst_n = 1'b1;
    step(3);
    chk("R1 stay unpowered", mode, M_UNP);
    vs_ok = 1'b1;
    step(1);
    chk("R1 to prenorm", mode, M_PRE);
    // R3 pre-normal
    chk("R3 outs", {reg_on, term_en, wd_en}, 3'b111);
    txd = 1'b0; #1;
    chk("R3 no drive", bus_drv, 1'b0);
    txd = 1'b1;
    wake_n = 1'b0; step(LOCW + 2);
    chk("R12 wake ignored prenorm", {mode, rxd, txd_oe}, {M_PRE, 1'b1, 1'b0});
    wake_n = 1'b1;
    en = 1'b1; step(1);
    chk("R3 to normal", mode, M_NOR);

    // random traffic in normal
    low_run = 0;
    for (int i = 0; i < 150; i++) begin
      txd = (low_run >= 10) ? 1'b1 : 1'($urandom % 2);
      bus_dom = 1'($urandom % 2);
      wake_n = ($urandom % 4) != 0;
      #1;
      chk("R3 drive follows txd", bus_drv, exp_drive(txd, low_run));
      chk("R3 rxd follows bus", rxd, exp_rxd_normal(bus_dom));
      step(1);
      low_run = txd ? 0 : low_run + 1;
      chk("R12 normal holds", mode, M_NOR);
    end
    txd = 1'b1; bus_dom = 1'b0; wake_n = 1'b1;
    step(2);

    // undervoltage in normal
    vcc_uv = 1'b1; step(1);
    chk("R5 uv normal", mode, M_PRE);
    vcc_uv = 1'b0; step(1);
    chk("R3 back normal", mode, M_NOR);

    // select window aborts
    en = 1'b0; step(2);
    txd = 1'b0; step(SEL + 2);
    chk("R4 txd change aborts", mode, M_NOR);
    txd = 1'b1; en = 1'b1; step(1);
    en = 1'b0; step(2);
    en = 1'b1; step(SEL + 2);
    chk("R4 en return aborts", mode, M_NOR);

    // silent entry
    en = 1'b0; step(SEL - 1);
    chk("R4 window not done", mode, M_NOR);
    step(2);
    chk("R4 silent", mode, M_SIL);
    chk("R5 silent outs", {reg_on, term_en, wd_en, bus_drv, rxd}, 5'b10001);
    bus_dom = 1'b1; step(BUSW - 1);
    bus_dom = 1'b0; step(2);
    chk("R7 short pulse", mode, M_SIL);
    en = 1'b1; step(1);
    chk("R5 silent direct normal", mode, M_NOR);

    enter_low(1'b1);
    chk("R4 silent again", mode, M_SIL);
    vcc_uv = 1'b1; step(1);
    chk("R5 uv silent", mode, M_PRE);
    chk("R5 no wake flag", {rxd, txd_oe}, 2'b10);
    vcc_uv = 1'b0; en = 1'b1; step(1);

    // sleep and local wake
    enter_low(1'b0);
    chk("R4 sleep", mode, M_SLP);
    chk("R6 sleep outs", {reg_on, term_en, wd_en, rxd}, 4'b0);
    en = 1'b1; step(3);
    chk("R6 en ignored", mode, M_SLP);
    vcc_uv = 1'b1; step(2);
    chk("R6 uv ignored", mode, M_SLP);
    en = 1'b0; vcc_uv = 1'b0;
    wake_n = 1'b0; step(LOCW - 1);
    chk("R8 not yet", mode, M_SLP);
    step(2);
    chk("R8 local wake", mode, M_PRE);
    chk("R9 local report", {rxd, txd_oe, txd_out, term_en, reg_on}, 5'b01011);
    wake_n = 1'b1; step(3);
    chk("R9 flags held", {rxd, txd_oe}, 2'b01);
    en = 1'b1; step(1);
    chk("R9 flags clear", {mode, txd_oe, rxd}, {M_NOR, 1'b0, 1'b1});

    // short local pulse then remote wake from silent
    enter_low(1'b1);
    wake_n = 1'b0; step(LOCW - 1);
    wake_n = 1'b1; step(2);
    chk("R8 short pulse", mode, M_SIL);
    bus_dom = 1'b1; step(BUSW - 1);
    chk("R7 not yet", mode, M_SIL);
    step(2);
    chk("R7 remote wake", mode, M_PRE);
    chk("R9 remote report", {rxd, txd_oe, txd_out, term_en}, 4'b0111);
    bus_dom = 1'b0; en = 1'b1; step(1);
    chk("R9 remote clear", {mode, txd_oe}, {M_NOR, 1'b0});

    // bus already dominant on entry
    bus_dom = 1'b1;
    enter_low(1'b1);
    step(BUSW + 4);
    chk("R12 held level no wake", mode, M_SIL);
    bus_dom = 1'b0; step(1);
    bus_dom = 1'b1; step(BUSW + 1);
    chk("R12 fresh edge wakes", mode, M_PRE);
    bus_dom = 1'b0; en = 1'b1; step(1);

    // dominant time-out and re-arm
    txd = 1'b0; step(DOM - 1);
    chk("R10 still driving", bus_drv, 1'b1);
    step(2);
    chk("R10 timed out", bus_drv, 1'b0);
    txd = 1'b1; step(REARM - 1);
    txd = 1'b0; step(1);
    chk("R11 short high", bus_drv, 1'b0);
    txd = 1'b1; step(REARM + 1);
    txd = 1'b0; #1;
    chk("R11 re-armed", bus_drv, 1'b1);
    txd = 1'b1; step(1);

    // supply loss from silent and from normal
    enter_low(1'b1);
    vs_ok = 1'b0; step(1);
    chk("R2 loss silent", {mode, reg_on}, {M_UNP, 1'b0});
    vs_ok = 1'b1; en = 1'b0; step(1);
    chk("R1 repower", mode, M_PRE);
    en = 1'b1; step(1);
    vs_ok = 1'b0; step(1);
    chk("R2 loss normal", mode, M_UNP);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule